// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block sits between a requester and a 16-bit memory that is built from two byte banks. The even bank holds the bytes at even addresses and the odd bank holds the bytes at odd addresses. The requester hands over one access at a time: a 20-bit byte address, a byte or word size, a read or write flag, and 16 bits of write data. The sequencer turns this into one or two bus cycles. Every bus cycle uses a pair-aligned address, and per-lane enables mark which banks take part. On reads it drops the bytes that were not asked for and returns the result little-endian, then gives a one-cycle completion pulse.

A word at an odd address spans two bank pairs, so it is split. The first bus cycle uses the odd lane of the lower pair and supplies the low byte. The second bus cycle uses the even lane of the next pair and supplies the high byte. A word whose odd half lies at the top of the address space wraps its second byte to address zero. Both the request side and the memory side are valid/ready handshakes. The request side accepts only while no access is in progress. The memory side holds every bus-cycle field steady while the memory withholds ready, for as many cycles as it likes. Memory read data is sampled in the cycle in which the memory handshake completes.

Top module: `lane_seq`

## Requirements
- R1: A word at an even address A makes one bus cycle with mem_addr = A and mem_lane = 2'b11 (bit 0 enables the even bank, carried on bits 7:0 of the memory data, and bit 1 enables the odd bank, on bits 15:8). A read returns rdata = mem_rdata, so the byte at A is rdata[7:0] and the byte at A+1 is rdata[15:8].
- R2: A word at an odd address A makes two bus cycles in this order. The first has mem_addr = A-1 and lane 2'b10. The second has mem_addr = A+1 and lane 2'b01. A read returns rdata[7:0] = mem_rdata[15:8] from the first cycle and rdata[15:8] = mem_rdata[7:0] from the second.
- R3: A byte at an even address A makes one bus cycle with mem_addr = A and lane 2'b01. A read returns rdata = {8'h00, mem_rdata[7:0]}.
- R4: A byte at an odd address A makes one bus cycle with mem_addr = A-1 and lane 2'b10. A read returns rdata = {8'h00, mem_rdata[15:8]}.
- R5: Writes place each byte on the data lane of its target bank and drive the unused lane to zero. The low byte of the write data goes to the lower address. For example, writing word 17FEh at 13698h drives mem_wdata = 17FEh, and a byte write of B at an odd address drives mem_wdata = {B, 8'h00}. mem_we is high on every bus cycle of a write and low on every bus cycle of a read.
- R6: While mem_valid is high, mem_addr[0] is 0 and mem_lane is not 2'b00.
- R7: req_ready is high exactly when no access is in progress. A request is taken on req_valid && req_ready, and its first bus cycle is presented in the next cycle. While busy, req_valid has no effect and causes no extra bus cycle.
- R8: done is high for exactly one cycle, the cycle after the last memory handshake of an access. rdata is valid at that time and holds until the next read completes. A write leaves rdata unchanged.
- R9: A word at address FFFFFh wraps its second bus cycle to mem_addr = 00000h.
- R10: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_lane, mem_we and mem_wdata stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 20 | Byte address of the request |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Assembled read result |
| mem_valid | output | 1 | Bus cycle presented |
| mem_ready | input | 1 | Memory takes or completes the bus cycle |
| mem_addr | output | 20 | Pair-aligned bus address |
| mem_lane | output | 2 | Lane enables: bit 0 even bank, bit 1 odd bank |
| mem_we | output | 1 | Bus cycle is a write |
| mem_wdata | output | 16 | Write data by lane |
| mem_rdata | input | 16 | Read data by lane, sampled at the handshake |

## Verification
A wrong phase or a stale captured request shows up in the first bus cycle after acceptance, as a wrong address parity, a wrong lane pattern or a second cycle where none belongs. A fault in the staging of the low byte of a split read is only visible at done, as a swapped or stale low byte in rdata. A fault in the stall hold shows at the first cycle in which mem_ready is low, where the bus fields change before the handshake completes. Random stall patterns on mem_ready, mixed with directed odd-word, wrap and byte-lane cases, bring each of these out within one access.

// File: rtl/ls_pkg.sv
package ls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_e;

  localparam logic [1:0] LANE_EVEN = 2'b01;
  localparam logic [1:0] LANE_ODD  = 2'b10;
  localparam logic [1:0] LANE_BOTH = 2'b11;
endpackage

// File: rtl/ls_ctrl.sv
module ls_ctrl
  import ls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mem_ready,
  output logic              req_ready,
  output logic              bus_valid,
  output logic              phase_second,
  output logic              beat_fire,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_word,
  output logic              cap_write,
  output logic [DATA_W-1:0] cap_wdata,
  output logic              done
);
  seq_state_e state_q, state_d;
  logic       split;
  logic       accept;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign bus_valid    = (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign phase_second = (state_q == ST_SECOND);
  assign beat_fire    = bus_valid && mem_ready;
  assign split        = cap_word && cap_addr[0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_FIRST;
      ST_FIRST:  if (mem_ready) state_d = split ? ST_SECOND : ST_IDLE;
      ST_SECOND: if (mem_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done      <= 1'b0;
      cap_addr  <= '0;
      cap_word  <= 1'b0;
      cap_write <= 1'b0;
      cap_wdata <= '0;
    end else begin
      state_q <= state_d;
      done    <= bus_valid && mem_ready && (state_d == ST_IDLE);
      if (accept) begin
        cap_addr  <= req_addr;
        cap_word  <= req_word;
        cap_write <= req_write;
        cap_wdata <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/ls_planner.sv
module ls_planner
  import ls_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              bus_valid,
  input  logic              phase_second,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              cap_word,
  input  logic [DATA_W-1:0] cap_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_lane,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [ADDR_W-2:0] PAIR_ONE = {{(ADDR_W-2){1'b0}}, 1'b1};

  logic [ADDR_W-2:0] pair_cur;
  logic [ADDR_W-2:0] pair_nxt;
  logic              odd;
  logic [LANE_W-1:0] lo_byte;
  logic [LANE_W-1:0] hi_byte;

  assign pair_cur = cap_addr[ADDR_W-1:1];
  assign pair_nxt = pair_cur + PAIR_ONE;
  assign odd      = cap_addr[0];
  assign lo_byte  = cap_wdata[LANE_W-1:0];
  assign hi_byte  = cap_wdata[DATA_W-1:LANE_W];

  always_comb begin
    mem_addr  = '0;
    mem_lane  = 2'b00;
    mem_wdata = '0;
    if (bus_valid) begin
      if (phase_second) begin
        mem_addr  = {pair_nxt, 1'b0};
        mem_lane  = LANE_EVEN;
        mem_wdata = {{LANE_W{1'b0}}, hi_byte};
      end else begin
        mem_addr = {pair_cur, 1'b0};
        if (odd)           mem_lane = LANE_ODD;
        else if (cap_word) mem_lane = LANE_BOTH;
        else               mem_lane = LANE_EVEN;
        if (odd)           mem_wdata = {lo_byte, {LANE_W{1'b0}}};
        else if (cap_word) mem_wdata = {hi_byte, lo_byte};
        else               mem_wdata = {{LANE_W{1'b0}}, lo_byte};
      end
    end
  end
endmodule

// File: rtl/ls_assembler.sv
module ls_assembler #(
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_fire,
  input  logic              phase_second,
  input  logic              cap_word,
  input  logic              cap_odd,
  input  logic              cap_write,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [LANE_W-1:0] stage_q;
  logic [LANE_W-1:0] even_b;
  logic [LANE_W-1:0] odd_b;

  assign even_b = mem_rdata[LANE_W-1:0];
  assign odd_b  = mem_rdata[DATA_W-1:LANE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      rdata   <= '0;
    end else if (beat_fire && !cap_write) begin
      if (phase_second) begin
        rdata <= {even_b, stage_q};
      end else if (cap_word && cap_odd) begin
        stage_q <= odd_b;
      end else if (cap_word) begin
        rdata <= mem_rdata;
      end else begin
        rdata <= {{LANE_W{1'b0}}, (cap_odd ? odd_b : even_b)};
      end
    end
  end
endmodule

// File: rtl/lane_seq.sv
module lane_seq #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_lane,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              phase_second;
  logic              beat_fire;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_word;
  logic              cap_write;
  logic [DATA_W-1:0] cap_wdata;

  ls_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_word     (req_word),
    .req_write    (req_write),
    .req_wdata    (req_wdata),
    .mem_ready    (mem_ready),
    .req_ready    (req_ready),
    .bus_valid    (mem_valid),
    .phase_second (phase_second),
    .beat_fire    (beat_fire),
    .cap_addr     (cap_addr),
    .cap_word     (cap_word),
    .cap_write    (cap_write),
    .cap_wdata    (cap_wdata),
    .done         (done)
  );

  ls_planner #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_plan (
    .bus_valid    (mem_valid),
    .phase_second (phase_second),
    .cap_addr     (cap_addr),
    .cap_word     (cap_word),
    .cap_wdata    (cap_wdata),
    .mem_addr     (mem_addr),
    .mem_lane     (mem_lane),
    .mem_wdata    (mem_wdata)
  );

  ls_assembler #(.LANE_W(LANE_W)) u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_fire    (beat_fire),
    .phase_second (phase_second),
    .cap_word     (cap_word),
    .cap_odd      (cap_addr[0]),
    .cap_write    (cap_write),
    .mem_rdata    (mem_rdata),
    .rdata        (rdata)
  );

  assign mem_we = mem_valid && cap_write;
endmodule

// File: rtl/lane_seq_chk.sv
module lane_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_lane,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata
);
  a_r6_addr_even: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[0] == 1'b0));

  a_r6_lane_live: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_lane != 2'b00));

  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_valid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !mem_valid));

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_lane)
                                   && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind lane_seq lane_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_lane  (mem_lane),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata)
);

// File: tb/lane_seq_bench.sv
module lane_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [19:0] mem_addr;
  logic [1:0]  mem_lane;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit stall_on = 1'b1;

  logic [7:0]  mem_m [int];
  int          n_log = 0;
  logic [19:0] log_addr [4];
  logic [1:0]  log_lane [4];
  logic        log_we [4];
  logic [15:0] log_wdata [4];
  logic [15:0] last_rd = 16'h0000;

  logic        p_stall = 1'b0;
  logic [19:0] p_addr;
  logic [1:0]  p_lane;
  logic        p_we;
  logic [15:0] p_wdata;

  lane_seq u_lane_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_lane(mem_lane),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] rd_b(input logic [19:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model, bus logging and stall-hold check, all at the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n && p_stall) begin
      chk(mem_valid && mem_addr == p_addr && mem_lane == p_lane && mem_we == p_we
          && mem_wdata == p_wdata, "R10", "bus fields held under stall",
          {12'h0, mem_addr}, {12'h0, p_addr});
    end
    mem_ready = rst_n && (!stall_on || ($urandom_range(0, 3) != 0));
    if (mem_valid) mem_rdata = {rd_b(mem_addr + 20'd1), rd_b(mem_addr)};
    p_stall = mem_valid && !mem_ready;
    p_addr = mem_addr; p_lane = mem_lane; p_we = mem_we; p_wdata = mem_wdata;
    if (mem_valid && mem_ready) begin
      if (n_log < 4) begin
        log_addr[n_log] = mem_addr; log_lane[n_log] = mem_lane;
        log_we[n_log] = mem_we; log_wdata[n_log] = mem_wdata;
      end
      n_log++;
      if (mem_we) begin
        if (mem_lane[0]) mem_m[int'(mem_addr)] = mem_wdata[7:0];
        if (mem_lane[1]) mem_m[int'(mem_addr + 20'd1)] = mem_wdata[15:8];
      end
    end
  end

  function automatic logic [19:0] exp_addr(input logic [19:0] a, input int k);
    logic [19:0] base;
    base = {a[19:1], 1'b0};
    return (k == 0) ? base : base + 20'd2;
  endfunction

  function automatic logic [1:0] exp_lane(input logic [19:0] a, input bit w, input int k);
    if (k == 1) return 2'b01;
    if (a[0]) return 2'b10;
    return w ? 2'b11 : 2'b01;
  endfunction

  function automatic logic [15:0] exp_wd(input logic [19:0] a, input bit w,
                                        input logic [15:0] d, input int k);
    if (k == 1) return {8'h00, d[15:8]};
    if (a[0]) return {d[7:0], 8'h00};
    return w ? d : {8'h00, d[7:0]};
  endfunction

  task automatic run_req(input logic [19:0] a, input bit w, input bit wr,
                         input logic [15:0] d, input bit poke_busy);
    string       tag;
    int          n_exp;
    int          guard;
    logic [15:0] exp_rd;
    tag = w ? (a[0] ? "R2" : "R1") : (a[0] ? "R4" : "R3");
    if (w && a == 20'hFFFFF) tag = "R9";
    n_exp = (w && a[0]) ? 2 : 1;
    exp_rd = w ? {rd_b(a + 20'd1), rd_b(a)} : {8'h00, rd_b(a)};
    @(negedge clk);
    chk(req_ready, "R7", "idle before request", {31'h0, req_ready}, 32'h1);
    n_log = 0;
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 300) begin
      if (mem_valid && req_ready) chk(1'b0, "R7", "ready while busy", 32'h1, 32'h0);
      if (poke_busy && guard == 0) begin
        req_valid = 1'b1; req_addr = a ^ 20'h00F0F; req_word = ~w;
      end else if (poke_busy) begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    chk(done, tag, "done seen", {31'h0, done}, 32'h1);
    chk(req_ready, "R7", "ready with done", {31'h0, req_ready}, 32'h1);
    if (wr) chk(rdata == last_rd, "R8", "write leaves rdata", {16'h0, rdata}, {16'h0, last_rd});
    else begin
      chk(rdata == exp_rd, tag, "read data", {16'h0, rdata}, {16'h0, exp_rd});
      last_rd = exp_rd;
    end
    chk(n_log == n_exp, tag, "bus cycle count", n_log, n_exp);
    for (int k = 0; k < n_exp && k < n_log; k++) begin
      chk(log_addr[k] == exp_addr(a, k), (k == 1 && a == 20'hFFFFF) ? "R9" : tag,
          "bus address", {12'h0, log_addr[k]}, {12'h0, exp_addr(a, k)});
      chk(log_lane[k] == exp_lane(a, w, k), tag, "lane enables",
          {30'h0, log_lane[k]}, {30'h0, exp_lane(a, w, k)});
      chk(log_we[k] == wr, "R5", "write strobe", {31'h0, log_we[k]}, {31'h0, wr});
      if (wr) chk(log_wdata[k] == exp_wd(a, w, d, k), "R5", "lane write data",
                  {16'h0, log_wdata[k]}, {16'h0, exp_wd(a, w, d, k)});
    end
    @(negedge clk);
    chk(!done, "R8", "done one cycle", {31'h0, done}, 32'h0);
    if (poke_busy) begin
      @(negedge clk);
      chk(n_log == n_exp && !mem_valid, "R7", "busy request ignored", n_log, n_exp);
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_valid && !done && rdata == 16'h0, "R7", "reset state",
        {15'h0, req_ready, rdata}, {15'h0, 1'b1, 16'h0});

    // Directed: word write at even address, then byte and word reads back.
    run_req(20'h13698, 1'b1, 1'b1, 16'h17FE, 1'b0);
    run_req(20'h13698, 1'b0, 1'b0, 16'h0, 1'b0);
    chk(rdata == 16'h00FE, "R3", "low byte at lower address", {16'h0, rdata}, 32'h00FE);
    run_req(20'h13699, 1'b0, 1'b0, 16'h0, 1'b0);
    chk(rdata == 16'h0017, "R4", "high byte at next address", {16'h0, rdata}, 32'h0017);
    run_req(20'h13698, 1'b1, 1'b0, 16'h0, 1'b1);
    // Directed: odd word write and read across a pair boundary.
    run_req(20'h01233, 1'b1, 1'b1, 16'h9A78, 1'b0);
    run_req(20'h01233, 1'b1, 1'b0, 16'h0, 1'b0);
    chk(rdata == 16'h9A78, "R2", "odd word reassembled", {16'h0, rdata}, 32'h9A78);
    run_req(20'h01232, 1'b0, 1'b0, 16'h0, 1'b0);
    // Directed: wrap at the top of the address space.
    run_req(20'hFFFFF, 1'b1, 1'b1, 16'hA55A, 1'b0);
    run_req(20'hFFFFF, 1'b1, 1'b0, 16'h0, 1'b1);
    run_req(20'h00000, 1'b0, 1'b0, 16'h0, 1'b0);
    chk(rdata == 16'h00A5, "R9", "wrapped byte at zero", {16'h0, rdata}, 32'h00A5);
    // Directed: no-stall back-to-back accesses.
    stall_on = 1'b0;
    run_req(20'h00401, 1'b0, 1'b1, 16'h00C3, 1'b0);
    run_req(20'h00401, 1'b1, 1'b0, 16'h0, 1'b0);
    stall_on = 1'b1;

    // Random mix in a small window so reads hit earlier writes.
    for (int i = 0; i < 400; i++) begin
      logic [19:0] ra;
      ra = ($urandom_range(0, 7) == 0) ? 20'hFFFF0 + 20'($urandom_range(0, 15))
                                       : 20'h20000 + 20'($urandom_range(0, 63));
      run_req(ra, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              16'($urandom), ($urandom_range(0, 9) == 0));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule